// File: doc/BRIEF.md
# Dual-Channel IDE Interrupt Status and Mask Unit

This block gathers the drive interrupt request and the bus-master-done indication from each of two IDE channels and presents them to the host through two byte-wide registers. It applies a polarity choice to each raw drive interrupt line. It then gates each channel's combined request with a per-channel mask bit and drives one interrupt output per channel.

Two register offsets are decoded. Offset 2 has two faces. A read returns the status of channel 0. A write goes to a separate mode register that holds the legacy-compatible and test-mode selections, and those bits are never readable. Offset 3 holds the two mask bits, which are read/write. The same offset also reports, read-only, the status of channel 1 and a legacy-header strap pin. Status bits follow their sources one clock later and are never latched.

Top module: `dide_irq_unit`

## Requirements
- R1: While reset is high, both mask bits, the legacy-compatible output and the test-mode output are 0. The status registers are cleared, so both channel interrupt outputs are 0.
- R2: A read at offset 2 returns the channel 0 bus-master status in bit 1 and the channel 0 drive status in bit 0. Bits 7 to 2 read as 0.
- R3: A write at offset 2 with bit 7 set loads bit 1 into the legacy-compatible output (1 = legacy, 0 = native) and bit 0 into the test-mode output (1 = test). A write at offset 2 with bit 7 clear leaves both outputs unchanged.
- R4: The mode bits written at offset 2 never appear in the data read back from offset 2.
- R5: A read at offset 3 returns the strap in bit 4, the channel 1 bus-master status in bit 3, the channel 1 drive status in bit 2, the channel 1 mask in bit 1 and the channel 0 mask in bit 0. Bits 7 to 5 read as 0.
- R6: A write at offset 3 updates only mask bits 1 and 0 (1 = masked). Status and strap bits are unaffected by the write.
- R7: Each channel's drive status is its raw line XOR its active-low select. With the select at 1, a low line gives status 1. With the select at 0, a high line gives status 1.
- R8: Status bits take the value of their sources one clock after the source is sampled. They return to 0 one clock after the source deasserts.
- R9: Each channel's interrupt output equals (drive status OR bus-master status) AND NOT that channel's mask bit.
- R10: Writes at offsets 0 and 1 change no state. Reads at offsets 0 and 1 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 2 | Register offset |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| drv_irq_raw | input | 2 | Raw drive interrupt line per channel |
| irq_active_low | input | 2 | Per-channel polarity select, 1 = active-low |
| bm_done | input | 2 | Bus-master-done indication per channel |
| legacy_hdr_strap | input | 1 | Legacy-header presence strap |
| chan_irq | output | 2 | Masked interrupt output per channel |
| legacy_compat | output | 1 | Legacy-compatible mode selected |
| test_mode | output | 1 | Test mode selected |

## Verification
The bench builds the block with the package defaults: two channels, byte registers and a two-bit offset. With these values all four offsets can be reached, including the two undecoded ones, so stray writes and reads there are exercised next to the two live registers. A random phase mixes the polarity, raw-line, bus-master, strap and write patterns on every cycle. This mix reaches the cases where one offset serves two meanings and where masks and status interleave in the offset 3 byte.

// File: rtl/dide_irq_pkg.sv
package dide_irq_pkg;

    localparam int NUM_CH = 2;
    localparam int REG_W  = 8;
    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] OFS_STAT = ADDR_W'(2);
    localparam logic [ADDR_W-1:0] OFS_MASK = ADDR_W'(3);

    // Mode register field positions (write side of the status offset)
    localparam int MODE_KEY_BIT = 7;
    localparam int MODE_LEG_BIT = 1;
    localparam int MODE_TST_BIT = 0;

    // Field positions in the mask/status byte
    localparam int STRAP_BIT = 4;
    localparam int C1_BM_BIT = 3;
    localparam int C1_DR_BIT = 2;

    typedef struct packed {
        logic bm;
        logic drv;
    } chan_stat_t;

    typedef struct packed {
        logic legacy;
        logic test;
    } mode_t;

    function automatic logic [REG_W-1:0] status_byte(chan_stat_t s);
        logic [REG_W-1:0] r;
        r    = '0;
        r[1] = s.bm;
        r[0] = s.drv;
        return r;
    endfunction

    function automatic logic [REG_W-1:0] mask_byte(chan_stat_t s1, logic strap,
                                                   logic [NUM_CH-1:0] m);
        logic [REG_W-1:0] r;
        r             = '0;
        r[STRAP_BIT]  = strap;
        r[C1_BM_BIT]  = s1.bm;
        r[C1_DR_BIT]  = s1.drv;
        r[NUM_CH-1:0] = m;
        return r;
    endfunction

endpackage

// File: rtl/dide_irq_chan.sv
module dide_irq_chan
    import dide_irq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       raw_irq,
    input  logic       active_low,
    input  logic       bm_done,
    input  logic       masked,
    output chan_stat_t stat,
    output logic       irq
);

    // Level-following status, one register stage, no latching
    always_ff @(posedge clk) begin
        if (rst) begin
            stat <= '0;
        end else begin
            stat.drv <= raw_irq ^ active_low;
            stat.bm  <= bm_done;
        end
    end

    assign irq = (stat.drv | stat.bm) & ~masked;

endmodule

// File: rtl/dide_irq_mask.sv
module dide_irq_mask
    import dide_irq_pkg::*;
#(
    parameter int N = NUM_CH
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_hit,
    input  logic [N-1:0] wbits,
    output logic [N-1:0] mask
);

    always_ff @(posedge clk) begin
        if (rst) begin
            mask <= '0;
        end else if (wr_hit) begin
            mask <= wbits;
        end
    end

endmodule

// File: rtl/dide_irq_mode.sv
module dide_irq_mode
    import dide_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_hit,
    input  logic [REG_W-1:0] wdata,
    output mode_t            mode
);

    logic accept;
    logic unused_wbits;

    assign accept       = wr_hit & wdata[MODE_KEY_BIT];
    assign unused_wbits = ^wdata[MODE_KEY_BIT-1:MODE_LEG_BIT+1];

    always_ff @(posedge clk) begin
        if (rst) begin
            mode <= '0;
        end else if (accept) begin
            mode.legacy <= wdata[MODE_LEG_BIT];
            mode.test   <= wdata[MODE_TST_BIT];
        end
    end

endmodule

// File: rtl/dide_irq_rdmux.sv
module dide_irq_rdmux
    import dide_irq_pkg::*;
(
    input  logic [ADDR_W-1:0]         addr,
    input  chan_stat_t [NUM_CH-1:0]   stat,
    input  logic [NUM_CH-1:0]         mask,
    input  logic                      strap,
    output logic [REG_W-1:0]          rdata
);

    always_comb begin
        unique case (addr)
            OFS_STAT: rdata = status_byte(stat[0]);
            OFS_MASK: rdata = mask_byte(stat[1], strap, mask);
            default:  rdata = '0;
        endcase
    end

endmodule

// File: rtl/dide_irq_unit.sv
module dide_irq_unit
    import dide_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic [NUM_CH-1:0] drv_irq_raw,
    input  logic [NUM_CH-1:0] irq_active_low,
    input  logic [NUM_CH-1:0] bm_done,
    input  logic              legacy_hdr_strap,
    output logic [NUM_CH-1:0] chan_irq,
    output logic              legacy_compat,
    output logic              test_mode
);

    logic                    wr_mode_hit;
    logic                    wr_mask_hit;
    logic [NUM_CH-1:0]       mask_q;
    chan_stat_t [NUM_CH-1:0] stat;
    mode_t                   mode_q;

    assign wr_mode_hit = reg_wr && (reg_addr == OFS_STAT);
    assign wr_mask_hit = reg_wr && (reg_addr == OFS_MASK);

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        dide_irq_chan u_chan (
            .clk        (clk),
            .rst        (rst),
            .raw_irq    (drv_irq_raw[c]),
            .active_low (irq_active_low[c]),
            .bm_done    (bm_done[c]),
            .masked     (mask_q[c]),
            .stat       (stat[c]),
            .irq        (chan_irq[c])
        );
    end

    dide_irq_mask #(.N(NUM_CH)) u_mask (
        .clk    (clk),
        .rst    (rst),
        .wr_hit (wr_mask_hit),
        .wbits  (reg_wdata[NUM_CH-1:0]),
        .mask   (mask_q)
    );

    dide_irq_mode u_mode (
        .clk    (clk),
        .rst    (rst),
        .wr_hit (wr_mode_hit),
        .wdata  (reg_wdata),
        .mode   (mode_q)
    );

    dide_irq_rdmux u_rdmux (
        .addr  (reg_addr),
        .stat  (stat),
        .mask  (mask_q),
        .strap (legacy_hdr_strap),
        .rdata (reg_rdata)
    );

    assign legacy_compat = mode_q.legacy;
    assign test_mode     = mode_q.test;

endmodule

// File: rtl/dide_irq_unit_chk.sv
module dide_irq_unit_chk
    import dide_irq_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              reg_wr,
    input logic [REG_W-1:0]  reg_wdata,
    input logic [REG_W-1:0]  reg_rdata,
    input logic [NUM_CH-1:0] drv_irq_raw,
    input logic [NUM_CH-1:0] irq_active_low,
    input logic [NUM_CH-1:0] bm_done,
    input logic              legacy_hdr_strap,
    input logic [NUM_CH-1:0] chan_irq,
    input logic              legacy_compat,
    input logic              test_mode,
    input logic [NUM_CH-1:0] mask_q
);

    AST_MASK_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(reg_wr && reg_addr == OFS_MASK) |=> $stable(mask_q)); // R6

    AST_MODE_KEY: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == OFS_STAT && !reg_wdata[MODE_KEY_BIT])
        |=> $stable({legacy_compat, test_mode})); // R3

    AST_CH0_MASKED: assert property (@(posedge clk) disable iff (rst)
        mask_q[0] |-> !chan_irq[0]); // R9

    AST_CH1_MASKED: assert property (@(posedge clk) disable iff (rst)
        mask_q[1] |-> !chan_irq[1]); // R9

    AST_POLARITY: assert property (@(posedge clk) disable iff (rst)
        (reg_addr == OFS_STAT) |=>
        (reg_addr != OFS_STAT) ||
        (reg_rdata[0] == ($past(drv_irq_raw[0]) ^ $past(irq_active_low[0])))); // R7

    AST_BM_FOLLOW: assert property (@(posedge clk) disable iff (rst)
        (reg_addr == OFS_MASK) |=>
        (reg_addr != OFS_MASK) || (reg_rdata[C1_BM_BIT] == $past(bm_done[1]))); // R8

    AST_STAT_UPPER: assert property (@(posedge clk) disable iff (rst)
        (reg_addr == OFS_STAT) |-> (reg_rdata[REG_W-1:2] == '0)); // R4

    AST_STRAP_BIT: assert property (@(posedge clk) disable iff (rst)
        (reg_addr == OFS_MASK) |-> (reg_rdata[STRAP_BIT] == legacy_hdr_strap)); // R5

    AST_UNDECODED: assert property (@(posedge clk) disable iff (rst)
        (reg_addr != OFS_STAT && reg_addr != OFS_MASK) |-> (reg_rdata == '0)); // R10

endmodule

bind dide_irq_unit dide_irq_unit_chk u_chk (
    .clk              (clk),
    .rst              (rst),
    .reg_addr         (reg_addr),
    .reg_wr           (reg_wr),
    .reg_wdata        (reg_wdata),
    .reg_rdata        (reg_rdata),
    .drv_irq_raw      (drv_irq_raw),
    .irq_active_low   (irq_active_low),
    .bm_done          (bm_done),
    .legacy_hdr_strap (legacy_hdr_strap),
    .chan_irq         (chan_irq),
    .legacy_compat    (legacy_compat),
    .test_mode        (test_mode),
    .mask_q           (mask_q)
);

// File: tb/dide_irq_unit_test.sv
`timescale 1ns/1ps
module dide_irq_unit_test;

    logic       clk = 1'b0;
    logic       rst;
    logic [1:0] reg_addr;
    logic       reg_wr;
    logic [7:0] reg_wdata;
    logic [7:0] reg_rdata;
    logic [1:0] drv_irq_raw;
    logic [1:0] irq_active_low;
    logic [1:0] bm_done;
    logic       legacy_hdr_strap;
    logic [1:0] chan_irq;
    logic       legacy_compat;
    logic       test_mode;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    // Behavioural reference state
    logic [1:0] m_mask, m_drv, m_bm;
    logic       m_leg, m_tst;

    always #4 clk = ~clk;

    dide_irq_unit uut (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .drv_irq_raw(drv_irq_raw), .irq_active_low(irq_active_low),
        .bm_done(bm_done), .legacy_hdr_strap(legacy_hdr_strap),
        .chan_irq(chan_irq), .legacy_compat(legacy_compat), .test_mode(test_mode)
    );

    always @(posedge clk) begin
        if (rst) begin
            m_mask <= 2'b00; m_drv <= 2'b00; m_bm <= 2'b00;
            m_leg  <= 1'b0;  m_tst <= 1'b0;
        end else begin
            m_drv <= drv_irq_raw ^ irq_active_low;
            m_bm  <= bm_done;
            if (reg_wr && reg_addr == 2'd3) m_mask <= reg_wdata[1:0];
            if (reg_wr && reg_addr == 2'd2 && reg_wdata[7]) begin
                m_leg <= reg_wdata[1];
                m_tst <= reg_wdata[0];
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_rdata();
        case (reg_addr)
            2'd2:    return {6'b0, m_bm[0], m_drv[0]};
            2'd3:    return {3'b0, legacy_hdr_strap, m_bm[1], m_drv[1], m_mask};
            default: return 8'h00;
        endcase
    endfunction

    task automatic compare_all();
        if (reg_addr == 2'd2)      chk("R2 read offset 2", reg_rdata, exp_rdata());
        else if (reg_addr == 2'd3) chk("R5 read offset 3", reg_rdata, exp_rdata());
        else                       chk("R10 read undecoded", reg_rdata, exp_rdata());
        chk("R9 channel irq", chan_irq, ((m_drv | m_bm) & ~m_mask));
        chk("R3 mode outputs", {legacy_compat, test_mode}, {m_leg, m_tst});
    endtask

    task automatic cyc();
        @(negedge clk);
        compare_all();
    endtask

    task automatic write_reg(input logic [1:0] a, input logic [7:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        cyc();
        reg_wr = 1'b0;
    endtask

    task automatic finish_run();
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        rst = 1'b1; reg_addr = 2'd0; reg_wr = 1'b0; reg_wdata = 8'h00;
        drv_irq_raw = 2'b11; irq_active_low = 2'b00; bm_done = 2'b11;
        legacy_hdr_strap = 1'b0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 channel irq in reset", chan_irq, 2'b00);
        chk("R1 mode in reset", {legacy_compat, test_mode}, 2'b00);
        reg_addr = 2'd3;
        #1 chk("R1 mask byte in reset", reg_rdata, 8'h00);
        drv_irq_raw = 2'b00; bm_done = 2'b00;
        rst = 1'b0;
        cyc();

        // R3: keyed mode write, then unkeyed write ignored
        write_reg(2'd2, 8'h83);
        chk("R3 mode loaded", {legacy_compat, test_mode}, 2'b11);
        write_reg(2'd2, 8'h00);
        chk("R3 unkeyed write ignored", {legacy_compat, test_mode}, 2'b11);
        // R4: mode bits not visible on read
        reg_addr = 2'd2;
        cyc();
        chk("R4 offset 2 read hides mode", reg_rdata, 8'h00);
        write_reg(2'd2, 8'h82);
        chk("R3 legacy only", {legacy_compat, test_mode}, 2'b10);

        // R6: offset 3 write touches only masks
        write_reg(2'd3, 8'hFF);
        reg_addr = 2'd3;
        cyc();
        chk("R6 only mask bits written", reg_rdata, 8'h03);
        write_reg(2'd3, 8'hFC);
        cyc();
        chk("R6 masks cleared", reg_rdata, 8'h00);

        // R7: polarity
        reg_addr = 2'd2; irq_active_low = 2'b01; drv_irq_raw = 2'b00;
        cyc();
        chk("R7 active-low line low", reg_rdata[0], 1'b1);
        drv_irq_raw = 2'b01;
        cyc();
        chk("R7 active-low line high", reg_rdata[0], 1'b0);
        irq_active_low = 2'b00;
        cyc();
        chk("R7 active-high line high", reg_rdata[0], 1'b1);
        drv_irq_raw = 2'b00;

        // R8: level following, not latched
        reg_addr = 2'd3; bm_done = 2'b10;
        cyc();
        chk("R8 bm status set", reg_rdata[3], 1'b1);
        bm_done = 2'b00;
        cyc();
        chk("R8 bm status cleared", reg_rdata[3], 1'b0);

        // R10: writes to undecoded offsets
        write_reg(2'd3, 8'h01);
        write_reg(2'd0, 8'hFF);
        write_reg(2'd1, 8'hFE);
        reg_addr = 2'd3;
        cyc();
        chk("R10 mask unchanged", reg_rdata[1:0], 2'b01);
        chk("R10 mode unchanged", {legacy_compat, test_mode}, 2'b10);

        // Random mix
        for (int i = 0; i < 3000; i++) begin
            reg_addr         = 2'($urandom_range(0, 3));
            reg_wr           = ($urandom_range(0, 3) == 0);
            reg_wdata        = 8'($urandom);
            drv_irq_raw      = 2'($urandom);
            irq_active_low   = 2'($urandom);
            bm_done          = 2'($urandom);
            legacy_hdr_strap = 1'($urandom);
            cyc();
        end
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

endmodule